// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This block collects interrupt flags from a set of numbered peripheral groups and from one system group. It reduces them to a single registered request that tells the processor to jump to one shared, programmable vector address. Each flag counts only while its own enable bit is set. The qualified flags of a group are OR-ed into one pending bit per group, and these bits are shown in an identification word. Each pending bit then passes a per-group mask bit before it reaches the final gate. The final gate needs the global enable set and the in-service bit clear.

All sources have the same hardware priority, and only one interrupt is serviced at a time. Taking the vector sets the in-service bit, which blocks every further request. Software can nest interrupts by narrowing the mask inside a handler and then clearing the in-service bit directly. Flags are level inputs, and the owning peripheral clears them. The controller never latches a flag or clears one.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Identification bit g (g < NUM_GRP) is 1 exactly when some source s of group g has both `grp_flag[g*SRC_W+s]` and `grp_en[g*SRC_W+s]` set. This bit does not depend on the mask.
- R2: Identification bit NUM_GRP (the system group) is the OR of `sys_flag & sys_en`. Mask bit NUM_GRP gates the system group.
- R3: `irq_req` is registered. After a clock edge with no vector take, it equals the value before that edge of (global enable AND NOT in-service AND any bit of identification AND mask).
- R4: A group whose mask bit is 0 does not raise `irq_req`, even while its identification bit is 1.
- R5: While the global enable is 0, `irq_req` stays 0.
- R6: If `vec_take` is high while `irq_req` is high, the in-service bit is 1 and `irq_req` is 0 after that edge. If `vec_take` is high while `irq_req` is low, it has no effect on in-service.
- R7: A `reti` pulse clears the in-service bit at the next edge, unless a vector take is accepted in the same cycle. In that case the take wins.
- R8: A write to address 1 loads the global enable from data bit 0 and the in-service bit from data bit 1. Software uses this to clear in-service and nest.
- R9: A write to address 2 loads the vector register. A write to address 0 loads the mask register from the low NUM_GRP+1 data bits.
- R10: After reset, mask, global enable, in-service and `irq_req` are all 0, and the vector holds VEC_RST.
- R11: Flags are not latched. When a flag goes low, its identification bit goes low in the same cycle if no other qualified flag in that group is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_flag | input | NUM_GRP*SRC_W | Level flags of the numbered groups |
| grp_en | input | NUM_GRP*SRC_W | Local enables of the numbered groups |
| sys_flag | input | SYS_W | Level flags of the system group |
| sys_en | input | SYS_W | Local enables of the system group |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 mask, 1 control, 2 vector) |
| cfg_wdata | input | DW | Register write data |
| vec_take | input | 1 | Processor takes the vector |
| reti | input | 1 | Return from interrupt |
| irq_req | output | 1 | Registered request to jump to the vector |
| irq_id | output | NUM_GRP+1 | Per-group pending bits, system group in the top bit |
| mask_q | output | NUM_GRP+1 | Mask register |
| glob_en | output | 1 | Global enable |
| in_serv | output | 1 | In-service bit |
| vec_addr | output | DW | Vector address register |

## Verification
The hardest state to reach is the one where several controls meet at one edge. Examples are a take that coincides with a return, a take issued while the request is low, and a software clear of in-service while a flag is still pending. The bench walks through these in a directed sequence, checking in-service and the request one and two cycles later. It then runs seeded random flag, enable and mask patterns with in-service held clear, and compares the identification word and the registered request with values computed in the bench.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_VEC  = 2'd2
  } cfg_addr_e;

  localparam int CTRL_GE_BIT  = 0;
  localparam int CTRL_INS_BIT = 1;
endpackage

// File: rtl/irq_src_group.sv
module irq_src_group #(
  parameter int SRC_W = 8
) (
  input  logic [SRC_W-1:0] flag,
  input  logic [SRC_W-1:0] en,
  output logic             pend
);
  function automatic logic qualify(input logic [SRC_W-1:0] f, input logic [SRC_W-1:0] e);
    return |(f & e);
  endfunction

  assign pend = qualify(flag, en);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_tree_pkg::*;
#(
  parameter int IDW = 4,
  parameter int DW = 16,
  parameter logic [DW-1:0] VEC_RST = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           take_ok,
  input  logic           reti,
  output logic [IDW-1:0] mask_q,
  output logic           glob_en,
  output logic           in_serv,
  output logic [DW-1:0]  vec_addr
);
  logic wr_mask, wr_ctrl, wr_vec;
  assign wr_mask = cfg_we && (cfg_addr == ADDR_MASK);
  assign wr_ctrl = cfg_we && (cfg_addr == ADDR_CTRL);
  assign wr_vec  = cfg_we && (cfg_addr == ADDR_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      glob_en  <= 1'b0;
      in_serv  <= 1'b0;
      vec_addr <= VEC_RST;
    end else begin
      if (wr_mask) mask_q <= cfg_wdata[IDW-1:0];
      if (wr_vec) vec_addr <= cfg_wdata;
      if (wr_ctrl) glob_en <= cfg_wdata[CTRL_GE_BIT];
      if (take_ok)
        in_serv <= 1'b1;
      else if (reti)
        in_serv <= 1'b0;
      else if (wr_ctrl)
        in_serv <= cfg_wdata[CTRL_INS_BIT];
    end
  end

  // R6
  ins_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> in_serv);
  // R7
  reti_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take_ok) |=> !in_serv);
  // R6
  ins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_ok && !reti && !wr_ctrl) |=> $stable(in_serv));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] id_vec,
  input  logic [IDW-1:0] mask_q,
  input  logic           glob_en,
  input  logic           in_serv,
  input  logic           take_ok,
  output logic           irq_req
);
  function automatic logic gate_fn(input logic [IDW-1:0] id, input logic [IDW-1:0] m,
                                   input logic ge, input logic ins);
    return ge && !ins && (|(id & m));
  endfunction

  logic req_cond;
  assign req_cond = gate_fn(id_vec, mask_q, glob_en, in_serv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= req_cond && !take_ok;
  end

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> !irq_req);
  // R5
  req_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !irq_req);
  // R3
  req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(id_vec & mask_q)) || in_serv) |=> !irq_req);
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl #(
  parameter int NUM_GRP = 3,
  parameter int SRC_W = 8,
  parameter int SYS_W = 2,
  parameter int DW = 16,
  parameter logic [DW-1:0] VEC_RST = 16'h0100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GRP*SRC_W-1:0] grp_flag,
  input  logic [NUM_GRP*SRC_W-1:0] grp_en,
  input  logic [SYS_W-1:0]         sys_flag,
  input  logic [SYS_W-1:0]         sys_en,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  input  logic                     vec_take,
  input  logic                     reti,
  output logic                     irq_req,
  output logic [NUM_GRP:0]         irq_id,
  output logic [NUM_GRP:0]         mask_q,
  output logic                     glob_en,
  output logic                     in_serv,
  output logic [DW-1:0]            vec_addr
);
  localparam int IDW = NUM_GRP + 1;

  logic take_ok;
  assign take_ok = vec_take && irq_req;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    irq_src_group #(.SRC_W(SRC_W)) u_grp (
      .flag(grp_flag[g*SRC_W +: SRC_W]),
      .en  (grp_en[g*SRC_W +: SRC_W]),
      .pend(irq_id[g])
    );
  end

  irq_src_group #(.SRC_W(SYS_W)) u_sys (
    .flag(sys_flag),
    .en  (sys_en),
    .pend(irq_id[NUM_GRP])
  );

  irq_cfg_regs #(.IDW(IDW), .DW(DW), .VEC_RST(VEC_RST)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .take_ok, .reti,
    .mask_q, .glob_en, .in_serv, .vec_addr
  );

  irq_gate #(.IDW(IDW)) u_gate (
    .clk, .rst_n,
    .id_vec(irq_id), .mask_q, .glob_en, .in_serv, .take_ok,
    .irq_req
  );

  // R2
  sys_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_flag & sys_en) == '0 |-> !irq_id[NUM_GRP]);
endmodule

// File: tb/irq_tree_ctrl_test.sv
module irq_tree_ctrl_test;
  localparam int NG = 3, SW = 8, YW = 2, DW = 16;
  localparam logic [DW-1:0] VR = 16'h0100;

  logic clk = 0, rst_n = 0;
  logic [NG*SW-1:0] grp_flag = '0, grp_en = '0;
  logic [YW-1:0] sys_flag = '0, sys_en = '0;
  logic cfg_we = 0; logic [1:0] cfg_addr = '0; logic [DW-1:0] cfg_wdata = '0;
  logic vec_take = 0, reti = 0;
  logic irq_req; logic [NG:0] irq_id, mask_q; logic glob_en, in_serv; logic [DW-1:0] vec_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_tree_ctrl #(.NUM_GRP(NG), .SRC_W(SW), .SYS_W(YW), .DW(DW), .VEC_RST(VR)) uut (.*);

  always #2 clk = ~clk;

  function automatic logic [NG:0] model_id(logic [NG*SW-1:0] f, logic [NG*SW-1:0] e,
                                           logic [YW-1:0] sf, logic [YW-1:0] se);
    logic [NG:0] r = '0;
    for (int i = 0; i < NG*SW; i++) if (f[i] && e[i]) r[i/SW] = 1'b1;
    for (int j = 0; j < YW; j++) if (sf[j] && se[j]) r[NG] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; cyc(); cfg_we = 0;
  endtask

  initial begin
    #300000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(); cyc(); rst_n = 1; cyc();
    // R10 reset state
    chk("R10 req", irq_req, 0); chk("R10 mask", mask_q, 0);
    chk("R10 ge", glob_en, 0); chk("R10 ins", in_serv, 0); chk("R10 vec", vec_addr, VR);
    // R9 vector register
    wr(2'd2, 16'h1234); chk("R9 vec", vec_addr, 16'h1234);
    // R1 flag without enable, then with enable
    grp_flag[1*SW+3] = 1; #1 chk("R1 no-en", irq_id, 0);
    grp_en[1*SW+3] = 1; #1 chk("R1 id", irq_id, 4'b0010);
    cyc(); chk("R5 ge0", irq_req, 0);
    wr(2'd0, 16'h0002); chk("R9 mask", mask_q, 4'b0010);
    wr(2'd1, 16'h0001); cyc(); chk("R3 req", irq_req, 1);
    // R4 mask blocks
    wr(2'd0, 16'h0001); cyc(); chk("R4 masked", irq_req, 0);
    chk("R1 id unmasked view", irq_id, 4'b0010);
    // R6 take ignored while req low
    vec_take = 1; cyc(); vec_take = 0; chk("R6 ignored", in_serv, 0);
    wr(2'd0, 16'h0002); cyc(); chk("R3 req back", irq_req, 1);
    // R6 take accepted
    vec_take = 1; cyc(); vec_take = 0;
    chk("R6 ins", in_serv, 1); chk("R6 req drop", irq_req, 0);
    cyc(); chk("R6 blocked", irq_req, 0);
    // R7 return
    reti = 1; cyc(); reti = 0; chk("R7 ins", in_serv, 0);
    cyc(); chk("R7 req", irq_req, 1);
    // R7 take wins over reti
    vec_take = 1; reti = 1; cyc(); vec_take = 0; reti = 0; chk("R7 take wins", in_serv, 1);
    // R8 software clear of in-service
    wr(2'd1, 16'h0001); chk("R8 ins clr", in_serv, 0); chk("R8 ge", glob_en, 1);
    cyc(); chk("R8 req", irq_req, 1);
    // R2 system group
    wr(2'd0, 16'h0008); sys_flag = 2'b10; sys_en = 2'b10; #1 chk("R2 id", irq_id, 4'b1010);
    cyc(); chk("R2 req", irq_req, 1);
    // R11 flags not latched
    grp_flag[1*SW+3] = 0; #1 chk("R11 id", irq_id, 4'b1000);
    sys_flag = 0; cyc(); chk("R11 req", irq_req, 0);
    // random R1/R2/R3
    for (int it = 0; it < 200; it++) begin
      logic [NG:0] m; logic ge, er; logic [NG:0] eid;
      m = NG'($urandom) ; m = $urandom; ge = $urandom;
      wr(2'd0, DW'(m)); wr(2'd1, {14'd0, 1'b0, ge});
      grp_flag = $urandom; grp_en = $urandom; sys_flag = $urandom; sys_en = $urandom;
      eid = model_id(grp_flag, grp_en, sys_flag, sys_en);
      #1 chk("R1 R2 rand id", irq_id, eid);
      er = ge && ((eid & m) != 0);
      cyc(); chk("R3 rand req", irq_req, er);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule